// File: doc/BRIEF.md
# Brown-out and Power-up Reset Sequencer

This block drives the reset of a small processor core from a digital "supply is below threshold" flag. The flag comes from an external comparator. Short dips on the flag are rejected: the flag must stay high for a set number of slow-oscillator ticks before it counts as a brown-out. Reset stays asserted for as long as the supply is low. Once the supply is good again, an optional delay timer can hold reset for a further fixed interval, nominally 64 ms of oscillator ticks.

A 2-bit mode input chooses the detection policy: always on, always off, or on while awake and off during sleep. A watchdog request forces the core back into reset in the same way a brown-out does. A new qualified dip while the delay timer runs throws the sequence back to waiting for supply, and the full delay then runs again. A sticky status flag records that a brown-out has occurred, and software clears it with a dedicated input.

All pins are plain level control and status signals. There is no data stream, so no valid/ready handshake applies.

Top module: `bor_reset_seq`

## Requirements
- R1: While `rst_n` is low, `core_rst` is 1 and `bor_flag` is 0. After `rst_n` rises, `core_rst` stays 1 until `supply_low` is 0, in every mode.
- R2: With `pwrt_bypass` = 0, once `supply_low` is 0 in the wait phase, `core_rst` falls on the clock edge that samples the PWRT_TICKS-th `osc_tick`, and not before. PWRT_TICKS = OSC_HZ*PWRT_MS/1000.
- R3: With `pwrt_bypass` = 1 (delay disabled; 0 enables it), `core_rst` falls on the first clock edge at which `supply_low` is sampled 0 in the wait phase.
- R4: A `supply_low` pulse spanning fewer than QUAL_TICKS ticks has no effect: `core_rst` and `bor_flag` stay 0. The qualifier count clears whenever `supply_low` drops.
- R5: When `supply_low` stays high with detection on for QUAL_TICKS ticks, `core_rst` rises on the next clock and stays 1 until the supply is good, however fast or slowly the supply fell.
- R6: A qualified dip while the delay runs returns the block to waiting. After recovery, the full PWRT_TICKS delay runs again from zero.
- R7: Mode `bor_mode` = 2'b11 detects brown-outs at all times. Modes 2'b00 and 2'b01 ignore `supply_low` once the core has left reset.
- R8: In mode 2'b10, `supply_low` is ignored while `sleep` = 1, and detection works while `sleep` = 0.
- R9: `bor_flag` is set when a qualified brown-out pulls the core out of the delay or run phase. It stays set until `status_clr` is 1, and a new brown-out in the same cycle wins over the clear.
- R10: `wdt_req` = 1 forces `core_rst` to 1 on the next clock and restarts the full delay after that, without setting `bor_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| osc_tick | input | 1 | One-cycle pulse per slow-oscillator period |
| supply_low | input | 1 | Comparator output, 1 = supply under threshold |
| bor_mode | input | 2 | Detection mode: 11 on, 10 off in sleep, 00/01 off |
| pwrt_bypass | input | 1 | 1 skips the power-up delay, 0 enables it |
| sleep | input | 1 | Core is in sleep |
| wdt_req | input | 1 | Watchdog reset request |
| status_clr | input | 1 | Clears the sticky brown-out flag |
| core_rst | output | 1 | Reset to the core, active high |
| bor_flag | output | 1 | Sticky brown-out status |

## Verification
The bench builds the block with OSC_HZ = 1000 and PWRT_MS = 16, which gives a 16-tick delay, and with QUAL_TICKS = 4. Ticks are driven one every four clocks. At these values the exact release edge can be checked: reset must still be asserted one tick before the end of the delay and released one tick later. The same sizes make it practical to run a dip of QUAL_TICKS-1 ticks, a mid-delay restart, and sleep masking.

// File: rtl/bor_pkg.sv
package bor_pkg;
  typedef enum logic [1:0] {
    BM_OFF_A    = 2'b00,
    BM_OFF_B    = 2'b01,
    BM_SLEEPOFF = 2'b10,
    BM_ON       = 2'b11
  } bor_mode_e;

  typedef enum logic [1:0] {
    ST_WAIT_SUPPLY = 2'd0,
    ST_DELAY       = 2'd1,
    ST_RUN         = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bor_qual.sv
module bor_qual #(
  parameter int QUAL_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic supply_low,
  input  logic detect_en,
  output logic qualified
);
  localparam int CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

  logic [CW-1:0] qcnt;
  logic          armed;

  assign armed = supply_low && detect_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        qcnt <= '0;
    else if (!armed)                   qcnt <= '0;
    else if (osc_tick && qcnt != LIMIT) qcnt <= qcnt + 1'b1;
  end

  assign qualified = armed && (qcnt == LIMIT);

  // qualification can only complete on an oscillator tick
  assert_qual_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qualified) |-> $past(osc_tick));
endmodule

// File: rtl/pwrt_timer.sv
module pwrt_timer #(
  parameter int PWRT_TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(PWRT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(PWRT_TICKS - 1);

  logic [CW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        tcnt <= '0;
    else if (!run)                     tcnt <= '0;
    else if (osc_tick && tcnt != LAST) tcnt <= tcnt + 1'b1;
  end

  assign expire = run && osc_tick && (tcnt == LAST);

  // leaving run always restarts the interval from zero
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tcnt == '0));
endmodule

// File: rtl/bor_reset_seq.sv
module bor_reset_seq
  import bor_pkg::*;
#(
  parameter int OSC_HZ     = 31000,
  parameter int PWRT_MS    = 64,
  parameter int QUAL_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       supply_low,
  input  logic [1:0] bor_mode,
  input  logic       pwrt_bypass,
  input  logic       sleep,
  input  logic       wdt_req,
  input  logic       status_clr,
  output logic       core_rst,
  output logic       bor_flag
);
  localparam int PWRT_TICKS = (OSC_HZ * PWRT_MS) / 1000;

  seq_state_e state, state_nx;
  logic detect_en, qualified, expire, in_delay;

  always_comb begin
    unique case (bor_mode_e'(bor_mode))
      BM_ON:       detect_en = 1'b1;
      BM_SLEEPOFF: detect_en = !sleep;
      default:     detect_en = 1'b0;
    endcase
  end

  bor_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .supply_low(supply_low), .detect_en(detect_en), .qualified(qualified)
  );

  assign in_delay = (state == ST_DELAY);

  pwrt_timer #(.PWRT_TICKS(PWRT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .run(in_delay), .expire(expire)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_WAIT_SUPPLY:
        if (!supply_low && !wdt_req) state_nx = pwrt_bypass ? ST_RUN : ST_DELAY;
      ST_DELAY:
        if (qualified || wdt_req) state_nx = ST_WAIT_SUPPLY;
        else if (expire)          state_nx = ST_RUN;
      ST_RUN:
        if (qualified || wdt_req) state_nx = ST_WAIT_SUPPLY;
      default: state_nx = ST_WAIT_SUPPLY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_WAIT_SUPPLY;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        bor_flag <= 1'b0;
    else if (qualified && state != ST_WAIT_SUPPLY)     bor_flag <= 1'b1;
    else if (status_clr)                               bor_flag <= 1'b0;
  end

  assign core_rst = (state != ST_RUN);

  assert_rst_on_bor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    qualified |=> core_rst);
  assert_wdt_forces_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_req |=> core_rst);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_flag && !status_clr) |=> bor_flag);
  assert_release_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> ($past(pwrt_bypass) || $past(expire)));
  assert_sleep_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_mode == 2'b10 && sleep) |-> !qualified);
endmodule

// File: tb/sim_bor_reset_seq.sv
module sim_bor_reset_seq;
  localparam int QT = 4;
  localparam int PT = 16;

  logic clk = 1'b0;
  logic rst_n, osc_tick, supply_low, pwrt_bypass, sleep, wdt_req, status_clr;
  logic [1:0] bor_mode;
  logic core_rst, bor_flag;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  bor_reset_seq #(.OSC_HZ(1000), .PWRT_MS(16), .QUAL_TICKS(QT)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .supply_low(supply_low),
    .bor_mode(bor_mode), .pwrt_bypass(pwrt_bypass), .sleep(sleep),
    .wdt_req(wdt_req), .status_clr(status_clr),
    .core_rst(core_rst), .bor_flag(bor_flag)
  );

  // monitor: pops expectations and compares after the edge has settled
  always begin
    @(posedge clk);
    #2;
    while (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if ({core_rst, bor_flag} !== e) begin
        n_fail++;
        $display("FAIL %s: rst/flag actual %b%b expected %b%b", t, core_rst, bor_flag, e[1], e[0]);
      end
    end
  end

  task automatic expect_out(input logic r, input logic f, input string t);
    exp_q.push_back({r, f});
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      osc_tick = 1'b1; @(negedge clk);
      osc_tick = 1'b0; idle(3);
    end
  endtask

  task automatic pulse_in(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0; idle(2);
  endtask

  initial begin
    rst_n = 0; osc_tick = 0; supply_low = 1; bor_mode = 2'b11;
    pwrt_bypass = 0; sleep = 0; wdt_req = 0; status_clr = 0;
    idle(3);
    expect_out(1, 0, "R1 in power-on reset");
    rst_n = 1; idle(3);
    tick(2);
    expect_out(1, 0, "R1 held while supply low");
    // R2: full delay
    supply_low = 0; idle(2);
    tick(PT - 1);
    expect_out(1, 0, "R2 one tick before end of delay");
    tick(1);
    expect_out(0, 0, "R2 released after full delay");
    // R4: short dip
    supply_low = 1; tick(QT - 1); supply_low = 0; idle(2);
    expect_out(0, 0, "R4 short dip ignored");
    supply_low = 1; tick(QT - 1); supply_low = 0; idle(1);
    supply_low = 1; tick(1); supply_low = 0; idle(2);
    expect_out(0, 0, "R4 count clears between dips");
    // R5/R9: qualified brown-out
    supply_low = 1; tick(QT);
    expect_out(1, 1, "R5 R9 qualified brown-out");
    tick(6);
    expect_out(1, 1, "R5 held while supply low");
    // R6: dip during delay restarts
    supply_low = 0; idle(2); tick(PT / 2);
    supply_low = 1; tick(QT);
    expect_out(1, 1, "R6 mid-delay dip");
    supply_low = 0; idle(2); tick(PT - 1);
    expect_out(1, 1, "R6 full delay restarted");
    tick(1);
    expect_out(0, 1, "R6 release after restarted delay");
    // R9 clear
    pulse_in(status_clr);
    expect_out(0, 0, "R9 clear");
    // R10 watchdog
    pulse_in(wdt_req);
    expect_out(1, 0, "R10 watchdog reset");
    tick(PT - 1);
    expect_out(1, 0, "R10 delay restarted");
    tick(1);
    expect_out(0, 0, "R10 release");
    // R3 bypass
    pwrt_bypass = 1;
    supply_low = 1; tick(QT);
    expect_out(1, 1, "R3 brown-out with bypass");
    supply_low = 0; idle(1);
    expect_out(0, 1, "R3 immediate release");
    pulse_in(status_clr);
    // R8 sleep mask in mode 10
    bor_mode = 2'b10; sleep = 1; supply_low = 1; tick(QT + 2);
    expect_out(0, 0, "R8 ignored in sleep");
    sleep = 0; tick(QT);
    expect_out(1, 1, "R8 detection on wake");
    supply_low = 0; idle(2);
    pulse_in(status_clr);
    expect_out(0, 0, "R8 recovered");
    // R7 disabled modes
    bor_mode = 2'b00; supply_low = 1; tick(QT + 3);
    expect_out(0, 0, "R7 mode 00 ignores low supply");
    bor_mode = 2'b01; tick(QT + 3);
    expect_out(0, 0, "R7 mode 01 ignores low supply");
    bor_mode = 2'b11; tick(QT);
    expect_out(1, 1, "R7 mode 11 detects");
    idle(4);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule